// File: doc/BRIEF.md
# Block transfer and search sequencer

This block runs string-style block operations on behalf of a processor core. A single command carries out one of four kinds of work: a memory-to-memory copy, a search of memory for the accumulator value, a port-to-memory input or a memory-to-port output. Each kind can step addresses upward or downward. Each kind can also run as one step or repeat until its stop condition is met.

The block holds its own working copies of a 16-bit source pointer, a 16-bit destination pointer, a 16-bit count, an 8-bit port address and an 8-bit port counter. It also holds the accumulator and the flag byte. All of these are loaded when `start` is seen while idle. The block then drives a byte memory port and an I/O port, each with a request/acknowledge handshake. When it has finished, it raises `done` for one cycle, with the final pointers, counters and flags visible at the outputs.

The flag byte uses fixed bit positions: sign bit 7, zero bit 6, half-carry bit 4, parity/overflow bit 2, add/subtract bit 1 and carry bit 0. Bits 5 and 3 always pass through unchanged.

Top module: `blkmove_seq`

## Requirements
- R1: Copy (kind 0) reads memory at the source pointer, writes that byte to memory at the destination pointer, moves both pointers by one and decrements the 16-bit count.
- R2: A copy step clears half-carry (bit 4) and add/subtract (bit 1), sets parity/overflow (bit 2) to 1 exactly when the new count is non-zero, and leaves sign, zero and carry untouched.
- R3: Repeating copy continues until the 16-bit count reaches 0 and ends with bits 4, 2 and 1 all 0.
- R4: Search (kind 1) reads memory at the source pointer and forms acc minus byte. It sets sign to bit 7 of that result, zero to (result == 0), half-carry to (acc[3:0] < byte[3:0]), parity/overflow to (new count != 0) and add/subtract to 1. It keeps carry, moves the source pointer, decrements the count and makes no write.
- R5: Repeating search stops after the first step whose byte equals the accumulator, or when the count reaches 0, whichever comes first.
- R6: Input (kind 2) reads the I/O port at the port address, writes that byte to memory at the source pointer, moves the source pointer and decrements the 8-bit port counter. It sets zero to (new port counter == 0), sets add/subtract to 1 and leaves the 16-bit count and other flags unchanged.
- R7: Output (kind 3) reads memory at the source pointer and writes that byte to the I/O port at the port address. It updates the pointer, the port counter and the flags as in R6.
- R8: Repeating input and output continue until the 8-bit port counter reaches 0 and end with zero = 1 and add/subtract = 1.
- R9: At most one of the memory and I/O requests is high at any time. A raised request keeps its address, direction and write data until it is acknowledged.
- R10: A start value of 0 in a counter gives the full range: 256 iterations for a repeating I/O command, and a count of 0xFFFF with parity/overflow 1 after a single copy.
- R11: With `dir_down` = 0 the pointers move by +1. With `dir_down` = 1 they move by -1, and the destination always moves with the source.
- R12: `done` is high for exactly one cycle after the final access. `busy` is high from the cycle after `start` until that point. A `start`, or a change to the command inputs, while busy has no effect on the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (taken only while idle) |
| kind | input | 2 | 0 copy, 1 search, 2 input, 3 output |
| dir_down | input | 1 | 1 steps pointers downward |
| repeat_en | input | 1 | 1 repeats until the stop condition |
| src_init | input | 16 | Initial source pointer |
| dst_init | input | 16 | Initial destination pointer |
| cnt_init | input | 16 | Initial 16-bit count |
| port_init | input | 8 | Port address |
| pcnt_init | input | 8 | Initial 8-bit port counter |
| acc | input | 8 | Accumulator value for search |
| flags_init | input | 8 | Initial flag byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| io_req | output | 1 | Port access request |
| io_we | output | 1 | 1 write, 0 read |
| io_addr | output | 8 | Port address |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, valid with ack |
| io_ack | input | 1 | Port acknowledge |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| src_q | output | 16 | Current source pointer |
| dst_q | output | 16 | Current destination pointer |
| cnt_q | output | 16 | Current 16-bit count |
| pcnt_q | output | 8 | Current port counter |
| flags_q | output | 8 | Current flag byte |

## Verification
The assertions assume that each acknowledge is raised only while its own request is high and lasts for a single cycle. They also assume that read data is valid in the cycle its acknowledge is high. The bench's responders follow this. Each responder waits a random 0 to 2 cycles after seeing a request, raises the acknowledge for one clock with the data for that address or port, and drops it before looking at the next request. Commands are started only from idle, except in one deliberate case: a second `start` with different command inputs is issued mid-run to show that it is ignored.

// File: rtl/blkmove_seq.sv
`timescale 1ns/1ps
module blkmove_seq #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    kind,
  input  logic          dir_down,
  input  logic          repeat_en,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [AW-1:0] cnt_init,
  input  logic [PW-1:0] port_init,
  input  logic [PW-1:0] pcnt_init,
  input  logic [7:0]    acc,
  input  logic [7:0]    flags_init,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack,
  output logic          io_req,
  output logic          io_we,
  output logic [PW-1:0] io_addr,
  output logic [7:0]    io_wdata,
  input  logic [7:0]    io_rdata,
  input  logic          io_ack,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [AW-1:0] cnt_q,
  output logic [PW-1:0] pcnt_q,
  output logic [7:0]    flags_q
);
  localparam logic [1:0] K_COPY = 2'd0;
  localparam logic [1:0] K_SRCH = 2'd1;
  localparam logic [1:0] K_IN   = 2'd2;
  localparam logic [1:0] K_OUT  = 2'd3;
  localparam int FS = 7, FZ = 6, FH = 4, FP = 2, FN = 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [1:0]    op;
  logic          down, rep, done_r;
  logic [7:0]    a_r, byte_r, flg, flg_n;
  logic [AW-1:0] src, dst, cnt;
  logic [PW-1:0] port, pcnt;

  wire is_copy = op == K_COPY;
  wire is_srch = op == K_SRCH;
  wire is_in   = op == K_IN;
  wire is_out  = op == K_OUT;
  wire is_io   = is_in | is_out;

  assign mem_req   = (st == S_RD && !is_in) || (st == S_WR && !is_out);
  assign io_req    = (st == S_RD && is_in) || (st == S_WR && is_out);
  assign mem_we    = st == S_WR;
  assign io_we     = st == S_WR;
  assign mem_addr  = (st == S_WR && is_copy) ? dst : src;
  assign io_addr   = port;
  assign mem_wdata = byte_r;
  assign io_wdata  = byte_r;

  wire       rd_ack  = is_in ? io_ack : mem_ack;
  wire       wr_ack  = is_out ? io_ack : mem_ack;
  wire [7:0] rd_byte = is_in ? io_rdata : mem_rdata;
  wire       step_end = (st == S_RD && rd_ack && is_srch) || (st == S_WR && wr_ack);

  wire [7:0]    diff   = a_r - rd_byte;
  wire          hb     = a_r[3:0] < rd_byte[3:0];
  wire [AW-1:0] cnt_n  = cnt - 1'b1;
  wire [PW-1:0] pcnt_n = pcnt - 1'b1;
  wire [AW-1:0] src_n  = down ? src - 1'b1 : src + 1'b1;
  wire [AW-1:0] dst_n  = down ? dst - 1'b1 : dst + 1'b1;

  wire more = rep && ((is_copy && cnt_n != '0) ||
                      (is_srch && cnt_n != '0 && diff != 8'd0) ||
                      (is_io && pcnt_n != '0));

  always_comb begin
    flg_n = flg;
    if (is_copy) begin
      flg_n[FH] = 1'b0;
      flg_n[FN] = 1'b0;
      flg_n[FP] = cnt_n != '0;
    end else if (is_srch) begin
      flg_n[FS] = diff[7];
      flg_n[FZ] = diff == 8'd0;
      flg_n[FH] = hb;
      flg_n[FP] = cnt_n != '0;
      flg_n[FN] = 1'b1;
    end else begin
      flg_n[FZ] = pcnt_n == '0;
      flg_n[FN] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op <= K_COPY;
      down <= 1'b0;
      rep <= 1'b0;
      done_r <= 1'b0;
      a_r <= '0;
      byte_r <= '0;
      flg <= '0;
      src <= '0;
      dst <= '0;
      cnt <= '0;
      port <= '0;
      pcnt <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op <= kind;
          down <= dir_down;
          rep <= repeat_en;
          a_r <= acc;
          flg <= flags_init;
          src <= src_init;
          dst <= dst_init;
          cnt <= cnt_init;
          port <= port_init;
          pcnt <= pcnt_init;
          st <= S_RD;
        end
        S_RD: if (rd_ack) begin
          byte_r <= rd_byte;
          st <= is_srch ? (more ? S_RD : S_IDLE) : S_WR;
        end
        S_WR: if (wr_ack) st <= more ? S_RD : S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (step_end) begin
        flg <= flg_n;
        src <= src_n;
        if (is_copy) dst <= dst_n;
        if (is_io) pcnt <= pcnt_n;
        else cnt <= cnt_n;
        done_r <= !more;
      end
    end
  end

  assign busy    = st != S_IDLE;
  assign done    = done_r;
  assign src_q   = src;
  assign dst_q   = dst;
  assign cnt_q   = cnt;
  assign pcnt_q  = pcnt;
  assign flags_q = flg;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !(mem_req && io_req)); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !io_ack |=> io_req && $stable(io_we) && $stable(io_wdata)); // R9
  AST_COPY_END: assert property (@(posedge clk) disable iff (!rst_n)
    done && is_copy && rep |-> cnt == '0 && flg[FP] == 1'b0 && flg[FH] == 1'b0 && flg[FN] == 1'b0); // R3
  AST_SRCH_END: assert property (@(posedge clk) disable iff (!rst_n)
    done && is_srch && rep |-> (cnt == '0 || flg[FZ]) && flg[FN]); // R5
  AST_IO_END: assert property (@(posedge clk) disable iff (!rst_n)
    done && is_io && rep |-> pcnt == '0 && flg[FZ] && flg[FN]); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !io_req); // R12
endmodule

// File: tb/test_blkmove_seq.sv
`timescale 1ns/1ps
module test_blkmove_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] kind = '0;
  logic dir_down = 1'b0, repeat_en = 1'b0;
  logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
  logic [7:0] port_init = '0, pcnt_init = '0, acc = '0, flags_init = '0;
  logic mem_req, mem_we, io_req, io_we, busy, done;
  logic [15:0] mem_addr, src_q, dst_q, cnt_q;
  logic [7:0] mem_wdata, io_addr, io_wdata, pcnt_q, flags_q;
  logic [7:0] mem_rdata = '0, io_rdata = '0;
  logic mem_ack = 1'b0, io_ack = 1'b0;

  always #2.5 clk = ~clk;

  blkmove_seq i_blkmove_seq (.*);

  int nchk = 0, nfail = 0;
  bit finished = 0;
  string cur_req = "R1";

  logic [7:0] mem [int];
  logic [7:0] mm [int];
  logic [25:0] expq [$];
  int rk = 0;

  function automatic logic [7:0] dflt(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] iov(logic [7:0] p, int k);
    logic [7:0] kk = 8'(k);
    return p ^ (kk * 8'd29) ^ 8'h6B;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, expv);
    end
  endtask

  task automatic poke(logic [15:0] a, logic [7:0] v);
    mem[int'(a)] = v;
    mm[int'(a)] = v;
  endtask

  // responders: one-cycle acknowledge after 0..2 cycles of wait
  int mwait = 0, iwait = 0;
  logic [25:0] mlat, ilat;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      if (mlat[24]) mem[int'(mlat[23:8])] = mlat[7:0];
      if (expq.size() == 0) chk({cur_req, " extra mem access"}, {6'd0, mlat}, 32'hFFFFFFFF);
      else chk({cur_req, " mem access"}, {6'd0, mlat}, {6'd0, expq.pop_front()});
    end else if (mem_req) begin
      if (mwait == 0) begin
        logic [7:0] d;
        d = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : dflt(mem_addr);
        if (mem_we) d = mem_wdata;
        mlat = {1'b0, mem_we, mem_addr, d};
        mem_rdata = d;
        mem_ack = 1'b1;
        mwait = $urandom_range(0, 2);
      end else mwait--;
    end
    if (io_ack) begin
      io_ack = 1'b0;
      if (expq.size() == 0) chk({cur_req, " extra io access"}, {6'd0, ilat}, 32'hFFFFFFFF);
      else chk({cur_req, " io access"}, {6'd0, ilat}, {6'd0, expq.pop_front()});
    end else if (io_req) begin
      if (iwait == 0) begin
        logic [7:0] d;
        d = io_we ? io_wdata : iov(io_addr, rk);
        if (!io_we) rk++;
        ilat = {1'b1, io_we, 8'd0, io_addr, d};
        io_rdata = d;
        io_ack = 1'b1;
        iwait = $urandom_range(0, 2);
      end else iwait--;
    end
  end

  function automatic logic [7:0] mrd(logic [15:0] a);
    return mm.exists(int'(a)) ? mm[int'(a)] : dflt(a);
  endfunction

  task automatic run(string rq, logic [1:0] k, logic dn, logic rp, logic [15:0] s0, logic [15:0] d0,
                     logic [15:0] c0, logic [7:0] p0, logic [7:0] pc0, logic [7:0] a0, logic [7:0] f0,
                     bit jam = 0);
    logic [15:0] s = s0, d = d0, c = c0;
    logic [7:0] pc = pc0, f = f0, b, r;
    int mk = 0, guard = 0;
    bit more;
    cur_req = rq;
    expq.delete();
    rk = 0;
    do begin
      case (k)
        2'd0: begin
          b = mrd(s);
          expq.push_back({2'b00, s, b});
          expq.push_back({2'b01, d, b});
          mm[int'(d)] = b;
          s = dn ? s - 1 : s + 1; d = dn ? d - 1 : d + 1; c = c - 1;
          f[4] = 0; f[1] = 0; f[2] = c != 0;
          more = c != 0;
        end
        2'd1: begin
          b = mrd(s);
          expq.push_back({2'b00, s, b});
          r = a0 - b;
          f[7] = r[7]; f[6] = r == 0; f[4] = a0[3:0] < b[3:0];
          s = dn ? s - 1 : s + 1; c = c - 1;
          f[2] = c != 0; f[1] = 1;
          more = c != 0 && r != 0;
        end
        2'd2: begin
          b = iov(p0, mk); mk++;
          expq.push_back({2'b10, 8'd0, p0, b});
          expq.push_back({2'b01, s, b});
          mm[int'(s)] = b;
          s = dn ? s - 1 : s + 1; pc = pc - 1;
          f[6] = pc == 0; f[1] = 1;
          more = pc != 0;
        end
        default: begin
          b = mrd(s);
          expq.push_back({2'b00, s, b});
          expq.push_back({2'b11, 8'd0, p0, b});
          s = dn ? s - 1 : s + 1; pc = pc - 1;
          f[6] = pc == 0; f[1] = 1;
          more = pc != 0;
        end
      endcase
    end while (rp && more);

    @(negedge clk);
    kind = k; dir_down = dn; repeat_en = rp; src_init = s0; dst_init = d0; cnt_init = c0;
    port_init = p0; pcnt_init = pc0; acc = a0; flags_init = f0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({rq, " busy after start (R12)"}, {31'd0, busy}, 32'd1);
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (jam && guard == 4) begin
        kind = ~k; dir_down = ~dn; src_init = 16'h7777; acc = ~a0; start = 1'b1;
      end else if (jam && guard == 5) start = 1'b0;
    end
    chk({rq, " done seen"}, {31'd0, done}, 32'd1);
    chk({rq, " src"}, {16'd0, src_q}, {16'd0, s});
    chk({rq, " dst"}, {16'd0, dst_q}, {16'd0, (k == 2'd0) ? d : d0});
    chk({rq, " cnt"}, {16'd0, cnt_q}, {16'd0, c});
    chk({rq, " pcnt"}, {24'd0, pcnt_q}, {24'd0, pc});
    chk({rq, " flags"}, {24'd0, flags_q}, {24'd0, f});
    @(negedge clk);
    chk({rq, " done single cycle (R12)"}, {30'd0, done, busy}, 32'd0);
    chk({rq, " all accesses seen (R9)"}, expq.size(), 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset busy/done", {30'd0, busy, done}, 32'd0);
    chk("R9 reset requests", {30'd0, mem_req, io_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R1 R2 copy single up",   2'd0, 0, 0, 16'h1000, 16'h2000, 16'd5, 8'h00, 8'h00, 8'h00, 8'hFF);
    run("R2 R10 copy single cnt1", 2'd0, 0, 0, 16'h1100, 16'h2100, 16'd1, 8'h00, 8'h00, 8'h00, 8'h16);
    run("R10 copy single cnt0",   2'd0, 1, 0, 16'h1200, 16'h2200, 16'd0, 8'h00, 8'h00, 8'h00, 8'h00);
    run("R3 R11 copy repeat up",  2'd0, 0, 1, 16'h3000, 16'h3100, 16'd8, 8'h00, 8'h00, 8'h00, 8'hD7);
    run("R3 R11 copy repeat down overlap", 2'd0, 1, 1, 16'h3007, 16'h3009, 16'd6, 8'h00, 8'h00, 8'h00, 8'h00);
    run("R1 R11 copy wrap down",  2'd0, 1, 1, 16'h0001, 16'hFFFF, 16'd3, 8'h00, 8'h00, 8'h00, 8'h28);

    poke(16'h4003, 8'h3C);
    run("R4 search single",       2'd1, 0, 0, 16'h4001, 16'h0000, 16'd9, 8'h00, 8'h00, 8'h3C, 8'h01);
    run("R5 search repeat match", 2'd1, 0, 1, 16'h4000, 16'h0000, 16'd9, 8'h00, 8'h00, 8'h3C, 8'h00);
    run("R5 R11 search repeat exhaust down", 2'd1, 1, 1, 16'h4100, 16'h0000, 16'd5, 8'h00, 8'h00, 8'h00, 8'hC0);
    poke(16'h4200, 8'h3C);
    run("R4 search single match", 2'd1, 0, 0, 16'h4200, 16'h0000, 16'd1, 8'h00, 8'h00, 8'h3C, 8'h00);

    run("R6 input single",        2'd2, 0, 0, 16'h5000, 16'h0000, 16'h1234, 8'h42, 8'd3, 8'h00, 8'h81);
    run("R6 R8 input repeat up",  2'd2, 0, 1, 16'h5010, 16'h0000, 16'h0000, 8'h43, 8'd4, 8'h00, 8'h00);
    run("R8 R10 input repeat 256", 2'd2, 1, 1, 16'h5300, 16'h0000, 16'h0000, 8'h44, 8'd0, 8'h00, 8'h00);
    run("R7 output single",       2'd3, 1, 0, 16'h5305, 16'h0000, 16'h0007, 8'h90, 8'd1, 8'h00, 8'h00);
    run("R7 R8 output repeat down", 2'd3, 1, 1, 16'h5310, 16'h0000, 16'h0007, 8'h91, 8'd6, 8'h00, 8'hFF);

    run("R12 start while busy ignored", 2'd0, 0, 1, 16'h6000, 16'h6100, 16'd10, 8'h00, 8'h00, 8'h00, 8'h00, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule